// File: doc/BRIEF.md
# Multi-Lane Serial Broadcast Receiver

This block sits on the receive side of a module attached to a serial broadcast fabric. Each peer module drives its own send lane. This block watches several of those lanes at the same time, three by default. A lane has a data wire, a bit clock wire and an attention wire. While attention is high, every rising edge of the lane clock shifts one bit into that lane's deserializer. After nine bits the lane has a full character: eight data bits followed by one odd-parity bit. The eight data bits go into the lane's holding slot, together with the parity verdict.

Any lane that holds a character raises the shared interrupt line. The local controller sees which lane is asking, the character held there, and whether that character had a parity error or an overrun. The controller takes a character by issuing a clear for that lane. To refuse a character, because it is not addressed here or the module is busy, the controller simply never clears it. The lane then stays pending and does not take new characters.

Top module: `sbus_rx`

## Requirements
- R1: During and directly after synchronous reset, `irq` is 0 and `req_pending` is all zeros.
- R2: While a lane's attention is high, each rising edge of its bit clock captures one data bit, most significant bit first. The ninth captured bit is the parity bit. Once it is captured, the eight data bits appear on `req_char` and that lane's bit in `req_pending` goes to 1.
- R3: Parity is odd. `req_perr` is 0 when the nine captured bits together hold an odd number of ones, and 1 when they hold an even number.
- R4: When attention drops partway through a character, the bits captured so far are thrown away. The next character on that lane starts again from its first bit.
- R5: Bit clock edges that arrive while a lane's attention is low capture nothing and change no output.
- R6: `irq` is 1 exactly when at least one lane holds an unread character.
- R7: `req_id` gives the lowest-numbered pending lane. `req_char`, `req_perr` and `req_ovr` belong to that lane. With no lane pending, all four are 0.
- R8: A one-cycle `clr_en` with `clr_id` equal to i clears lane i's pending and overrun flags at the next clock. The other lanes are not affected. A pending lane that is not cleared stays pending.
- R9: When a lane finishes a new character while it is still pending, that lane's overrun flag is set and the character it already holds is kept.
- R10: The lanes capture at the same time and independently of each other. Characters that arrive together on several lanes are all held.
- R11: A clear aimed at a lane that is not pending, or at an index of NBUS or higher, changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_data | input | NBUS | Serial data wire of each lane |
| lane_clk | input | NBUS | Bit clock wire of each lane |
| lane_attn | input | NBUS | Attention wire of each lane; frames a character |
| irq | output | 1 | Interrupt toward the local controller |
| req_pending | output | NBUS | One bit per lane that holds an unread character |
| req_id | output | IDW | Index of the lowest pending lane |
| req_char | output | 8 | Character held by the reported lane |
| req_perr | output | 1 | Parity error flag of the reported lane |
| req_ovr | output | 1 | Overrun flag of the reported lane |
| clr_en | input | 1 | Clear strobe; marks the addressed lane's character as accepted |
| clr_id | input | IDW | Lane addressed by the clear strobe |

## Verification
Single characters with correct and with wrong parity show whether the shift order and the parity sense are right. Characters cut short by a drop in attention, and clock pulses sent while attention is low, show whether the framing logic restarts its bit count and ignores edges outside a frame. Pairs of characters on one lane with no clear between them show whether the overrun path keeps the old character. Random mixes of simultaneous arrivals and clears on random lanes, some out of range, show whether lanes interfere with each other and whether the priority pick is correct.

// File: rtl/sbus_rx_pkg.sv
package sbus_rx_pkg;

    localparam int CHAR_W  = 8;
    localparam int FRAME_W = CHAR_W + 1;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic              full;
        logic              ovr;
        logic              perr;
        logic [CHAR_W-1:0] data;
    } slot_t;

    // A frame passes when its ones count, parity bit included, is odd.
    function automatic logic frame_odd(input logic [FRAME_W-1:0] f);
        return ^f;
    endfunction

endpackage

// File: rtl/sbus_rx_sync.sv
module sbus_rx_sync #(
    parameter int W      = 3,
    parameter int STAGES = sbus_rx_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/sbus_rx_lane.sv
module sbus_rx_lane
    import sbus_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  s_data,
    input  logic  s_clk,
    input  logic  s_attn,
    input  logic  clr,
    output logic  done,
    output slot_t slot
);
    logic               clk_prev_q;
    logic [CNT_W-1:0]   bit_cnt_q;
    logic [CHAR_W-1:0]  shift_q;
    logic               rise;
    logic [FRAME_W-1:0] frame;
    slot_t              slot_q;
    slot_t              slot_d;

    assign rise  = s_clk & ~clk_prev_q;
    assign frame = {shift_q, s_data};
    assign done  = s_attn & rise & (bit_cnt_q == CNT_W'(FRAME_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_prev_q <= 1'b0;
            bit_cnt_q  <= '0;
            shift_q    <= '0;
        end else begin
            clk_prev_q <= s_clk;
            if (!s_attn) begin
                bit_cnt_q <= '0;
            end else if (rise) begin
                shift_q <= {shift_q[CHAR_W-2:0], s_data};
                if (bit_cnt_q == CNT_W'(FRAME_W - 1)) bit_cnt_q <= '0;
                else                                  bit_cnt_q <= bit_cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        slot_d      = slot_q;
        slot_d.full = slot_q.full & ~clr;
        slot_d.ovr  = slot_q.ovr  & ~clr;
        if (done) begin
            if (!slot_d.full) begin
                slot_d.full = 1'b1;
                slot_d.data = frame[FRAME_W-1:1];
                slot_d.perr = ~frame_odd(frame);
            end else begin
                slot_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_d;
    end

    assign slot = slot_q;
endmodule

// File: rtl/sbus_rx_pick.sv
module sbus_rx_pick
    import sbus_rx_pkg::*;
#(
    parameter int NBUS = 3,
    parameter int IDW  = 2
) (
    input  slot_t [NBUS-1:0]   slots,
    output logic  [NBUS-1:0]   pending,
    output logic  [IDW-1:0]    sel_id,
    output slot_t              sel
);
    always_comb begin
        sel    = '0;
        sel_id = '0;
        for (int i = NBUS - 1; i >= 0; i--) begin
            pending[i] = slots[i].full;
            if (slots[i].full) begin
                sel    = slots[i];
                sel_id = IDW'(i);
            end
        end
    end
endmodule

// File: rtl/sbus_rx.sv
module sbus_rx
    import sbus_rx_pkg::*;
#(
    parameter int NBUS = 3,
    localparam int IDW = (NBUS > 1) ? $clog2(NBUS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NBUS-1:0]   lane_data,
    input  logic [NBUS-1:0]   lane_clk,
    input  logic [NBUS-1:0]   lane_attn,
    output logic              irq,
    output logic [NBUS-1:0]   req_pending,
    output logic [IDW-1:0]    req_id,
    output logic [CHAR_W-1:0] req_char,
    output logic              req_perr,
    output logic              req_ovr,
    input  logic              clr_en,
    input  logic [IDW-1:0]    clr_id
);
    logic [3*NBUS-1:0] raw_in;
    logic [3*NBUS-1:0] sync_out;
    logic [NBUS-1:0]   d_s, c_s, a_s;
    logic [NBUS-1:0]   char_done;
    logic [NBUS-1:0]   ovr_vec;
    slot_t [NBUS-1:0]  slots;
    slot_t             sel;

    assign raw_in = {lane_attn, lane_clk, lane_data};

    sbus_rx_sync #(.W(3*NBUS)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_in),
        .dout (sync_out)
    );

    assign d_s = sync_out[NBUS-1:0];
    assign c_s = sync_out[2*NBUS-1:NBUS];
    assign a_s = sync_out[3*NBUS-1:2*NBUS];

    for (genvar g = 0; g < NBUS; g++) begin : g_lane
        logic hit;
        assign hit = clr_en && (clr_id == IDW'(g));

        sbus_rx_lane u_lane (
            .clk    (clk),
            .rst    (rst),
            .s_data (d_s[g]),
            .s_clk  (c_s[g]),
            .s_attn (a_s[g]),
            .clr    (hit),
            .done   (char_done[g]),
            .slot   (slots[g])
        );
        assign ovr_vec[g] = slots[g].ovr;
    end

    sbus_rx_pick #(.NBUS(NBUS), .IDW(IDW)) u_pick (
        .slots   (slots),
        .pending (req_pending),
        .sel_id  (req_id),
        .sel     (sel)
    );

    assign irq      = |req_pending;
    assign req_char = sel.data;
    assign req_perr = sel.perr;
    assign req_ovr  = sel.ovr;
endmodule

// File: rtl/sbus_rx_chk.sv
module sbus_rx_chk #(
    parameter int NBUS = 3,
    parameter int IDW  = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            irq,
    input logic [NBUS-1:0] req_pending,
    input logic [IDW-1:0]  req_id,
    input logic            clr_en,
    input logic [IDW-1:0]  clr_id,
    input logic [NBUS-1:0] char_done,
    input logic [NBUS-1:0] ovr_vec
);
    // R7: the reported lane is pending and no lower lane is
    a_r7_lowest_first: assert property (@(posedge clk) disable iff (rst)
        irq |-> (req_pending[req_id] &&
                 ((req_pending & ((NBUS'(1) << req_id) - NBUS'(1))) == '0)));

    // R6: the interrupt only rises after a lane finished a character
    a_r6_irq_after_done: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(|char_done));

    for (genvar i = 0; i < NBUS; i++) begin : g_lane_chk
        // R8: a lane that is not cleared stays pending
        a_r8_pend_holds: assert property (@(posedge clk) disable iff (rst)
            (req_pending[i] && !(clr_en && clr_id == IDW'(i))) |=> req_pending[i]);

        // R8: a clear with no new character drops the lane
        a_r8_clear_drops: assert property (@(posedge clk) disable iff (rst)
            (clr_en && clr_id == IDW'(i) && !char_done[i]) |=> !req_pending[i]);

        // R9: overrun only appears on a lane that was already holding
        a_r9_ovr_needs_full: assert property (@(posedge clk) disable iff (rst)
            $rose(ovr_vec[i]) |-> $past(req_pending[i]));
    end
endmodule

bind sbus_rx sbus_rx_chk #(.NBUS(NBUS), .IDW(IDW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq         (irq),
    .req_pending (req_pending),
    .req_id      (req_id),
    .clr_en      (clr_en),
    .clr_id      (clr_id),
    .char_done   (char_done),
    .ovr_vec     (ovr_vec)
);

// File: tb/sim_sbus_rx.sv
module sim_sbus_rx;
    localparam int NB = 3;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NB-1:0] lane_data = '0;
    logic [NB-1:0] lane_clk  = '0;
    logic [NB-1:0] lane_attn = '0;
    logic          irq;
    logic [NB-1:0] req_pending;
    logic [IW-1:0] req_id;
    logic [7:0]    req_char;
    logic          req_perr;
    logic          req_ovr;
    logic          clr_en = 1'b0;
    logic [IW-1:0] clr_id = '0;

    int n_tests = 0;
    int n_fail  = 0;

    bit       m_full [NB];
    bit       m_ovr  [NB];
    bit       m_perr [NB];
    bit [7:0] m_char [NB];

    always #2 clk = ~clk;

    sbus_rx #(.NBUS(NB)) u0 (
        .clk(clk), .rst(rst),
        .lane_data(lane_data), .lane_clk(lane_clk), .lane_attn(lane_attn),
        .irq(irq), .req_pending(req_pending), .req_id(req_id),
        .req_char(req_char), .req_perr(req_perr), .req_ovr(req_ovr),
        .clr_en(clr_en), .clr_id(clr_id)
    );

    function automatic bit [8:0] mk_frame(bit [7:0] c, bit good);
        return {c, good ? ~(^c) : (^c)};
    endfunction

    function automatic int low_pending();
        for (int i = 0; i < NB; i++) if (m_full[i]) return i;
        return -1;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        int lo = low_pending();
        int pend = 0;
        for (int i = 0; i < NB; i++) if (m_full[i]) pend |= (1 << i);
        chk(req, "pending", int'(req_pending), pend);
        chk(req, "irq R6", int'(irq), pend != 0);
        chk(req, "id R7", int'(req_id), lo < 0 ? 0 : lo);
        chk(req, "char", int'(req_char), lo < 0 ? 0 : int'(m_char[lo]));
        chk(req, "perr", int'(req_perr), lo < 0 ? 0 : int'(m_perr[lo]));
        chk(req, "ovr", int'(req_ovr), lo < 0 ? 0 : int'(m_ovr[lo]));
    endtask

    // drive nbits of a frame on lane b, MSB first
    task automatic send_bits(int b, bit [8:0] f, int nbits);
        lane_attn[b] = 1'b1;
        repeat (2) @(negedge clk);
        for (int k = 0; k < nbits; k++) begin
            lane_data[b] = f[8-k];
            repeat (3) @(negedge clk);
            lane_clk[b] = 1'b1;
            repeat (3) @(negedge clk);
            lane_clk[b] = 1'b0;
        end
        repeat (2) @(negedge clk);
        lane_attn[b] = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    function automatic void model_char(int b, bit [7:0] c, bit good);
        if (m_full[b]) m_ovr[b] = 1'b1;
        else begin
            m_full[b] = 1'b1;
            m_char[b] = c;
            m_perr[b] = !good;
        end
    endfunction

    task automatic send_char(int b, bit [7:0] c, bit good);
        send_bits(b, mk_frame(c, good), 9);
        model_char(b, c, good);
        repeat (4) @(negedge clk);
    endtask

    task automatic do_clear(int id);
        clr_en = 1'b1;
        clr_id = IW'(id);
        @(negedge clk);
        clr_en = 1'b0;
        if (id < NB) begin
            m_full[id] = 1'b0;
            m_ovr[id]  = 1'b0;
        end
        @(negedge clk);
    endtask

    initial begin
        bit [7:0] rc [NB];
        bit       rg [NB];
        int       mask;
        void'($urandom(32'h5EED));
        for (int i = 0; i < NB; i++) begin
            m_full[i] = 0; m_ovr[i] = 0; m_perr[i] = 0; m_char[i] = 0;
        end
        repeat (3) @(negedge clk);
        check_all("R1");
        rst = 1'b0;
        @(negedge clk);
        check_all("R1");

        // R2/R3 good parity on lane 0, MSB-first pattern
        send_char(0, 8'hA5, 1'b1);
        check_all("R2");
        do_clear(0);
        check_all("R8");

        // R3 bad parity
        send_char(0, 8'h81, 1'b0);
        check_all("R3");
        do_clear(0);

        // R4 partial frame then a full one
        send_bits(1, mk_frame(8'hFF, 1'b1), 5);
        repeat (4) @(negedge clk);
        check_all("R4");
        send_char(1, 8'h3C, 1'b1);
        check_all("R4");
        do_clear(1);

        // R5 clock pulses with attention low
        for (int k = 0; k < 9; k++) begin
            lane_data[2] = 1'b1;
            repeat (3) @(negedge clk);
            lane_clk[2] = 1'b1;
            repeat (3) @(negedge clk);
            lane_clk[2] = 1'b0;
        end
        repeat (4) @(negedge clk);
        check_all("R5");

        // R9 overrun keeps the first character
        send_char(2, 8'h5A, 1'b1);
        send_char(2, 8'hC3, 1'b0);
        check_all("R9");
        // R7 priority: lane 1 ahead of lane 2
        send_char(1, 8'h11, 1'b1);
        check_all("R7");
        // R11 clear of an idle lane and an out-of-range index
        do_clear(0);
        check_all("R11");
        do_clear(3);
        check_all("R11");
        do_clear(1);
        check_all("R7");
        do_clear(2);
        check_all("R8");

        // R10 random concurrent arrivals and clears
        for (int it = 0; it < 40; it++) begin
            mask = int'($urandom_range(7, 1));
            for (int b = 0; b < NB; b++) begin
                rc[b] = 8'($urandom());
                rg[b] = ($urandom_range(3, 0) != 0);
            end
            for (int b = 0; b < NB; b++) begin
                if (mask[b]) begin
                    automatic int bb = b;
                    automatic bit [8:0] ff = mk_frame(rc[b], rg[b]);
                    fork send_bits(bb, ff, 9); join_none
                end
            end
            wait fork;
            for (int b = 0; b < NB; b++) if (mask[b]) model_char(b, rc[b], rg[b]);
            repeat (4) @(negedge clk);
            check_all("R10");
            if ($urandom_range(1, 0) == 1) begin
                do_clear(int'($urandom_range(3, 0)));
                check_all("R8");
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule